// File: doc/BRIEF.md
# Debounced Wake Event Input

This block conditions a slow mechanical contact, such as a lid switch or a power button, for power-management logic. The raw pin passes through a two-flop synchronizer. It then goes through a stability filter that clocks on a slow reference tick. The filtered level changes only after the pin has stayed at the new value for a full window of consecutive ticks. With the default 1 kHz tick and a 16-tick window, that window is 16 ms.

A transition of the filtered level in the selected direction sets a sticky status bit. Software clears that bit by writing a one to the acknowledge input. The interrupt request is raised while the status is set and the event enable is on.

Clearing the function-select input turns the pin into a plain general-purpose input. In that mode the level output shows the synchronized pin with no filtering, and no event is recorded. The filter keeps tracking the pin in the background, so switching back into function mode does not create a false event. After reset, the filtered level is loaded from the first synchronized samples of the pin, and this load raises no event.

Top module: `wake_input_cond`

## Requirements
- R1: The filtered level changes only when the synchronized pin has differed from it on 16 consecutive tick pulses. The change happens on the clock edge that samples the 16th pulse. The pin reaches the filter through two flops, so a pin change needs 2 clock edges before the filter sees it.
- R2: If the synchronized pin returns to the filtered level on any clock, the stability count restarts from zero.
- R3: `edge_sel` = 1 selects low-to-high transitions of the filtered level, and `edge_sel` = 0 selects high-to-low. Only a transition in the selected direction sets `evt_status`. The status bit sets one clock after the level changes.
- R4: `evt_status` is sticky. It is cleared by a clock with `evt_ack` = 1. If a new event and an acknowledge fall on the same clock, the event wins and the status stays set.
- R5: `irq` is high exactly when `evt_status` and `evt_en` are both 1. When the enable is 0, a transition still sets the status.
- R6: With `func_sel` = 0, `level_out` shows the synchronized pin with no filtering, and `evt_status` is never set.
- R7: After reset, `evt_status` and `irq` are 0. Within 3 clocks, `level_out` equals the pin level held during reset, and that load raises no event.
- R8: The filter keeps running while `func_sel` = 0. Returning to `func_sel` = 1 after the pin has settled shows the settled level and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| tick_en | input | 1 | One-clock pulse at the reference tick rate (1 kHz) |
| pin_raw | input | 1 | Asynchronous raw contact input |
| edge_sel | input | 1 | 1: low-to-high transition is an event, 0: high-to-low |
| evt_en | input | 1 | Enables the interrupt request |
| func_sel | input | 1 | 1: debounced event function, 0: plain input |
| evt_ack | input | 1 | Write-one acknowledge that clears the status |
| level_out | output | 1 | Debounced level (function mode) or synchronized pin (plain input mode) |
| evt_status | output | 1 | Sticky event status |
| irq | output | 1 | Interrupt/wake request |

## Verification
The bench drives a pin that stays stable for exactly 15 ticks and then for a 16th tick. A filter that is off by one would flip one tick early or late. It also drops the pin for a single clock partway through a count: a design that keeps counting across the glitch instead of restarting would flip too soon. An acknowledge is placed on the same clock that a new event sets the status, so a design that gives the clear priority would lose the event. The bench also resets with the pin held high and leaves plain-input mode after the pin has moved. A design that seeded the level from zero, or stopped filtering in bypass, would report a false transition.

// File: rtl/wake_input_pkg.sv
package wake_input_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned WINDOW_TICKS_DEF = 16;

  typedef enum logic {
    DIR_FALL = 1'b0,
    DIR_RISE = 1'b1
  } edge_dir_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = d_in;
      end else begin : g_rest
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/wake_debounce.sv
module wake_debounce #(
  parameter int unsigned WINDOW = 16,
  parameter int unsigned PRIME  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic sync_in,
  output logic level,
  output logic flip_pulse
);
  localparam int unsigned CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam int unsigned PW = $clog2(PRIME + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(WINDOW - 1);
  localparam logic [PW-1:0] PRIME_DONE = PW'(PRIME);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] prime_q, prime_d;
  logic          lvl_q, lvl_d;
  logic          flip_q, flip_d;
  logic          primed;

  assign primed = (prime_q == PRIME_DONE);

  always_comb begin
    cnt_d   = cnt_q;
    prime_d = prime_q;
    lvl_d   = lvl_q;
    flip_d  = 1'b0;
    if (!primed) begin
      lvl_d   = sync_in;
      prime_d = prime_q + 1'b1;
      cnt_d   = '0;
    end else if (sync_in == lvl_q) begin
      cnt_d = '0;
    end else if (tick_en) begin
      if (cnt_q == CNT_LAST) begin
        lvl_d  = ~lvl_q;
        cnt_d  = '0;
        flip_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      prime_q <= '0;
      lvl_q   <= 1'b0;
      flip_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      prime_q <= prime_d;
      lvl_q   <= lvl_d;
      flip_q  <= flip_d;
    end
  end

  assign level      = lvl_q;
  assign flip_pulse = flip_q;

  // R1
  deb_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed) && (lvl_q != $past(lvl_q))) |-> $past(tick_en));

  // R2
  deb_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed) && (lvl_q != $past(lvl_q))) |-> ($past(sync_in) != $past(lvl_q)));
endmodule

// File: rtl/wake_event.sv
module wake_event
  import wake_input_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flip_pulse,
  input  logic level,
  input  logic edge_sel,
  input  logic func_sel,
  input  logic evt_en,
  input  logic evt_ack,
  output logic status,
  output logic irq
);
  edge_dir_e dir;
  logic      hit;
  logic      st_q, st_d;

  assign dir = edge_dir_e'(edge_sel);
  assign hit = flip_pulse && func_sel && (level == logic'(dir));

  always_comb begin
    st_d = st_q;
    if (hit)          st_d = 1'b1;
    else if (evt_ack) st_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 1'b0;
    else        st_q <= st_d;
  end

  assign status = st_q;
  assign irq    = st_q & evt_en;

  // R6
  evt_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q) |-> $past(flip_pulse && func_sel));

  // R3
  evt_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q) |-> ($past(level) == $past(edge_sel)));

  // R4
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q && !evt_ack) |=> st_q);
endmodule

// File: rtl/wake_input_cond.sv
module wake_input_cond
  import wake_input_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = SYNC_STAGES_DEF,
  parameter int unsigned WINDOW_TICKS = WINDOW_TICKS_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic pin_raw,
  input  logic edge_sel,
  input  logic evt_en,
  input  logic func_sel,
  input  logic evt_ack,
  output logic level_out,
  output logic evt_status,
  output logic irq
);
  localparam int unsigned PRIME_CYCLES = SYNC_STAGES + 1;

  logic pin_sync;
  logic deb_level;
  logic deb_flip;

  wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_raw),
    .d_out (pin_sync)
  );

  wake_debounce #(.WINDOW(WINDOW_TICKS), .PRIME(PRIME_CYCLES)) u_deb (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .sync_in    (pin_sync),
    .level      (deb_level),
    .flip_pulse (deb_flip)
  );

  wake_event u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .flip_pulse (deb_flip),
    .level      (deb_level),
    .edge_sel   (edge_sel),
    .func_sel   (func_sel),
    .evt_en     (evt_en),
    .evt_ack    (evt_ack),
    .status     (evt_status),
    .irq        (irq)
  );

  assign level_out = func_sel ? deb_level : pin_sync;

  // R5
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_status && evt_en));
endmodule

// File: tb/sim_wake_input_cond.sv
module sim_wake_input_cond;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic pin_raw = 1'b0;
  logic edge_sel = 1'b1;
  logic evt_en = 1'b0;
  logic func_sel = 1'b1;
  logic evt_ack = 1'b0;
  logic level_out, evt_status, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  wake_input_cond u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pin_raw(pin_raw),
    .edge_sel(edge_sel), .evt_en(evt_en), .func_sel(func_sel),
    .evt_ack(evt_ack), .level_out(level_out), .evt_status(evt_status),
    .irq(irq)
  );

  // fields: edge_sel, evt_en, func_sel, pin, ticks[4:0], exp level, status, irq
  typedef struct packed {
    logic       es;
    logic       en;
    logic       fs;
    logic       pin;
    logic [4:0] ticks;
    logic       lvl;
    logic       st;
    logic       irq;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b1, 1'b1, 5'd16, 1'b1, 1'b1, 1'b1}, // R3 rising, R5 irq
    '{1'b1, 1'b1, 1'b1, 1'b0, 5'd16, 1'b0, 1'b0, 1'b0}, // R3 falling not selected
    '{1'b0, 1'b1, 1'b1, 1'b1, 5'd15, 1'b0, 1'b0, 1'b0}, // R1 15 ticks too few
    '{1'b0, 1'b1, 1'b1, 1'b1, 5'd1,  1'b1, 1'b0, 1'b0}, // R1 16th tick, rising not selected
    '{1'b0, 1'b0, 1'b1, 1'b0, 5'd16, 1'b0, 1'b1, 1'b0}, // R5 status without irq
    '{1'b1, 1'b1, 1'b0, 1'b1, 5'd0,  1'b1, 1'b0, 1'b0}, // R6 plain input, no filter
    '{1'b1, 1'b1, 1'b0, 1'b1, 5'd16, 1'b1, 1'b0, 1'b0}, // R6 filter flips silently
    '{1'b1, 1'b1, 1'b1, 1'b1, 5'd0,  1'b1, 1'b0, 1'b0}  // R8 return, no event
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
      idle(1);
    end
  endtask

  task automatic ack_pulse();
    @(negedge clk) evt_ack = 1'b1;
    @(negedge clk) evt_ack = 1'b0;
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk);
    rst_n = 1'b0;
    pin_raw = pin;
    idle(3);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    do_reset(1'b0);
    idle(4);
    check("R7 status", evt_status, 1'b0);
    check("R7 irq", irq, 1'b0);
    check("R7 level", level_out, 1'b0);

    for (int v = 0; v < NV; v++) begin
      edge_sel = VECS[v].es;
      evt_en   = VECS[v].en;
      func_sel = VECS[v].fs;
      pin_raw  = VECS[v].pin;
      idle(3);
      ticks(int'(VECS[v].ticks));
      idle(3);
      check($sformatf("vec%0d level", v), level_out, VECS[v].lvl);
      check($sformatf("vec%0d status", v), evt_status, VECS[v].st);
      check($sformatf("vec%0d irq", v), irq, VECS[v].irq);
      ack_pulse();
      idle(1);
      check($sformatf("R4 vec%0d ack clear", v), evt_status, 1'b0);
    end

    // R7: reset with pin high loads level without event
    do_reset(1'b1);
    func_sel = 1'b1; edge_sel = 1'b1; evt_en = 1'b1;
    idle(4);
    check("R7 level from pin", level_out, 1'b1);
    check("R7 no event on load", evt_status, 1'b0);

    // R2: glitch restarts the count
    do_reset(1'b0);
    idle(4);
    pin_raw = 1'b1;
    idle(3);
    ticks(10);
    @(negedge clk) pin_raw = 1'b0;
    @(negedge clk) pin_raw = 1'b1;
    idle(3);
    ticks(10);
    idle(3);
    check("R2 glitch restart", level_out, 1'b0);
    ticks(6);
    idle(3);
    check("R2 full window after restart", level_out, 1'b1);
    check("R3 rising after glitch", evt_status, 1'b1);
    ack_pulse();

    // R4: ack on the same clock as a new set; the set wins
    edge_sel = 1'b0;
    pin_raw = 1'b0;
    idle(3);
    ticks(15);
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) begin tick_en = 1'b0; evt_ack = 1'b1; end
    @(negedge clk) evt_ack = 1'b0;
    idle(2);
    check("R4 set wins over ack", evt_status, 1'b1);
    check("R1 falling level", level_out, 1'b0);
    check("R5 irq with enable", irq, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule